// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block caches linear-to-physical page translations for 4 KB pages. It holds 32 entries arranged as 8 sets of 4 ways. Each entry keeps a 20-bit physical frame number and two permission bits. Those bits are the directory-level and table-level permissions already merged by the walker that filled the entry. A lookup is purely combinational. In the same cycle that a linear address and access type are presented, the block reports one of three results: a hit with the physical address, a permission fault, or a miss that asks an external page walker for a translation.

The walker answers a miss with a fill. The fill is written at the next clock edge into one way of the set the linear address selects. The way is chosen in this order: a way already holding the same tag, then the lowest-numbered invalid way, then the way named by a 3-bit pseudo-LRU tree kept for each set. A write to the page-directory base register is signalled on a flush input. A flush invalidates every entry at once. There is no way to invalidate a single entry.

Top module: `tlb_top`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss (`walk_req`=1, `lk_hit`=0, `lk_pfault`=0, `lk_phys`=0).
- R2: The set index is linear address bits [14:12] and the tag is bits [31:15]; 32 pages (4 tags in each of the 8 sets) can be resident together and all of them hit.
- R3: A lookup that matches a resident page with sufficient permission drives `lk_hit`=1 in the same cycle, with `lk_phys` = {stored frame, `lk_lin`[11:0]}.
- R4: When `lk_valid`=1 and no valid entry of the indexed set carries the tag, `walk_req`=1, `lk_hit`=0, `lk_pfault`=0 and `lk_phys`=0.
- R5: A user access (`lk_user`=1) to a matched page whose user bit (`fill_usr`) is 0 gives `lk_pfault`=1 and `lk_hit`=0, for both reads and writes.
- R6: A user write to a matched page whose writable bit (`fill_wr`) is 0 gives `lk_pfault`=1. A user read of that page hits, and a supervisor access of any kind to any matched page hits.
- R7: A fill whose tag is not resident goes into the lowest-numbered invalid way of its set, so four distinct tags filled into one set all stay resident.
- R8: When the set is full, the victim comes from a binary tree of 3 bits per set. The root bit selects ways {0,1} (0) or {2,3} (1), and the leaf bit selects the lower (0) or upper (1) way of that pair. Every fill and every lookup that matches an entry (hit or fault) sets the bits on its path to point away from the way it used. A fill takes precedence over a lookup in the same cycle.
- R9: A fill whose tag is already resident in its set overwrites that same way, so later lookups return the new frame and no other page of the set is displaced.
- R10: A cycle with `flush`=1 invalidates all entries at the next edge and clears the replacement bits; afterwards every earlier page misses.
- R11: A fill presented in the same cycle as `flush` is discarded.
- R12: At most one of `lk_hit`, `lk_pfault`, `walk_req` is high, and all three are low when `lk_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_lin | input | 32 | Linear address to translate |
| lk_user | input | 1 | 1 = user-level access, 0 = supervisor |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_hit | output | 1 | Translation found and permitted |
| lk_pfault | output | 1 | Translation found but access not permitted |
| lk_phys | output | 32 | Physical address on a match, 0 otherwise |
| walk_req | output | 1 | Miss: request to the external walker |
| fill_en | input | 1 | Walker delivers a translation |
| fill_lin | input | 32 | Linear address of the filled page (bits [11:0] ignored) |
| fill_frame | input | 20 | Physical frame number of the filled page |
| fill_usr | input | 1 | Merged user-accessible bit |
| fill_wr | input | 1 | Merged writable bit |
| flush | input | 1 | Page-directory base written: invalidate all entries |

## Verification
The properties assume that inputs are stable and known around every rising edge. They also assume that a supervisor lookup made in the cycle right after a fill, at that fill's page, is not blocked by a flush that lands between the two. The bench meets both conditions. It changes inputs only on falling edges, and it never lowers a lookup in the same cycle as a fill. This keeps replacement order predictable, and the bench relies on that to predict evictions.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned LIN_W    = 32;
  localparam int unsigned PG_OFF_W = 12;

  typedef struct packed {
    logic usr;  // user level may access
    logic wr;   // user level may write
  } tlb_perm_t;
endpackage

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int unsigned SETS  = 8,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 17,
  parameter int unsigned FRM_W = 20,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [FRM_W-1:0] wr_frm,
  input  tlb_perm_t        wr_perm,
  input  logic [SET_W-1:0] rd_set,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [WAYS-1:0]  rd_match,
  output logic [FRM_W-1:0] rd_frm,
  output tlb_perm_t        rd_perm,
  input  logic [SET_W-1:0] fl_set,
  input  logic [TAG_W-1:0] fl_tag,
  output logic [WAYS-1:0]  fl_match,
  output logic [WAYS-1:0]  fl_valid
);
  logic [SETS-1:0][WAYS-1:0]             valid_q, valid_d;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0][FRM_W-1:0]  frm_q;
  tlb_perm_t [SETS-1:0][WAYS-1:0]        perm_q;

  always_comb begin
    valid_d = valid_q;
    if (clr)
      valid_d = '0;
    else if (wr_en)
      valid_d[wr_set][wr_way] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way]  <= wr_tag;
      frm_q[wr_set][wr_way]  <= wr_frm;
      perm_q[wr_set][wr_way] <= wr_perm;
    end
  end

  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_cmp
      assign rd_match[w] = valid_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag);
      assign fl_match[w] = valid_q[fl_set][w] && (tag_q[fl_set][w] == fl_tag);
      assign fl_valid[w] = valid_q[fl_set][w];
    end
  endgenerate

  always_comb begin
    rd_frm  = '0;
    rd_perm = '0;
    for (int i = 0; i < WAYS; i++) begin
      rd_frm  = rd_frm  | (frm_q[rd_set][i] & {FRM_W{rd_match[i]}});
      rd_perm = rd_perm | (perm_q[rd_set][i] & {2{rd_match[i]}});
    end
  end
endmodule

// File: rtl/tlb_plru.sv
module tlb_plru #(
  parameter int unsigned SETS = 8,
  parameter int unsigned WAYS = 4,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned NB    = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic [WAY_W-1:0] upd_way,
  input  logic [SET_W-1:0] q_set,
  output logic [WAY_W-1:0] q_way
);
  logic [SETS-1:0][NB-1:0] tree_q, tree_d;

  // Heap numbering: node n (1..NB) lives in bit n-1; children 2n, 2n+1.
  function automatic logic [WAY_W-1:0] pick(input logic [NB-1:0] t);
    int n = 1;
    for (int l = 0; l < int'(WAY_W); l++)
      n = 2 * n + int'(t[n-1]);
    return WAY_W'(n - int'(WAYS));
  endfunction

  function automatic logic [NB-1:0] mark(input logic [NB-1:0] t,
                                         input logic [WAY_W-1:0] way);
    logic [NB-1:0] r;
    logic          dir;
    int            n;
    r = t;
    n = 1;
    for (int l = 0; l < int'(WAY_W); l++) begin
      dir      = way[int'(WAY_W) - 1 - l];
      r[n-1]   = ~dir;
      n        = 2 * n + int'(dir);
    end
    return r;
  endfunction

  always_comb begin
    tree_d = tree_q;
    if (clr)
      tree_d = '0;
    else if (upd_en)
      tree_d[upd_set] = mark(tree_q[upd_set], upd_way);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tree_q <= '0;
    else        tree_q <= tree_d;
  end

  assign q_way = pick(tree_q[q_set]);
endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int unsigned SET_W = 3,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned FRM_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [LIN_W-1:0] lk_lin,
  input  logic             lk_user,
  input  logic             lk_write,
  output logic             lk_hit,
  output logic             lk_pfault,
  output logic [LIN_W-1:0] lk_phys,
  output logic             walk_req,
  input  logic             fill_en,
  input  logic [LIN_W-1:0] fill_lin,
  input  logic [FRM_W-1:0] fill_frame,
  input  logic             fill_usr,
  input  logic             fill_wr,
  input  logic             flush
);
  localparam int unsigned SETS  = 1 << SET_W;
  localparam int unsigned TAG_W = LIN_W - PG_OFF_W - SET_W;
  localparam int unsigned WAY_W = $clog2(WAYS);

  logic [SET_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  logic [WAYS-1:0]  rd_match, fl_match, fl_valid;
  logic [FRM_W-1:0] rd_frm;
  tlb_perm_t        rd_perm, wr_perm;
  logic             any_match, viol;
  logic             wr_en, upd_en;
  logic [WAY_W-1:0] vic_way, fill_way, upd_way, lk_way;
  logic [SET_W-1:0] upd_set;

  assign lk_set = lk_lin[PG_OFF_W +: SET_W];
  assign lk_tag = lk_lin[LIN_W-1 -: TAG_W];
  assign fl_set = fill_lin[PG_OFF_W +: SET_W];
  assign fl_tag = fill_lin[LIN_W-1 -: TAG_W];

  assign wr_perm.usr = fill_usr;
  assign wr_perm.wr  = fill_wr;

  tlb_array #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .FRM_W(FRM_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .wr_en(wr_en), .wr_set(fl_set), .wr_way(fill_way),
    .wr_tag(fl_tag), .wr_frm(fill_frame), .wr_perm(wr_perm),
    .rd_set(lk_set), .rd_tag(lk_tag),
    .rd_match(rd_match), .rd_frm(rd_frm), .rd_perm(rd_perm),
    .fl_set(fl_set), .fl_tag(fl_tag),
    .fl_match(fl_match), .fl_valid(fl_valid)
  );

  tlb_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .upd_en(upd_en), .upd_set(upd_set), .upd_way(upd_way),
    .q_set(fl_set), .q_way(vic_way)
  );

  // Lookup decision
  assign any_match = lk_valid && (|rd_match);
  assign viol      = lk_user && (!rd_perm.usr || (lk_write && !rd_perm.wr));
  assign lk_hit    = any_match && !viol;
  assign lk_pfault = any_match && viol;
  assign walk_req  = lk_valid && !(|rd_match);
  assign lk_phys   = any_match ? {rd_frm, lk_lin[PG_OFF_W-1:0]} : '0;

  always_comb begin
    lk_way = '0;
    for (int w = 0; w < int'(WAYS); w++)
      if (rd_match[w]) lk_way = WAY_W'(w);
  end

  // Fill way: resident tag, else lowest invalid, else tree victim
  always_comb begin
    logic             got_match, got_inv;
    logic [WAY_W-1:0] m_way, i_way;
    got_match = 1'b0;
    got_inv   = 1'b0;
    m_way     = '0;
    i_way     = '0;
    for (int w = int'(WAYS) - 1; w >= 0; w--) begin
      if (fl_match[w]) begin
        got_match = 1'b1;
        m_way     = WAY_W'(w);
      end
      if (!fl_valid[w]) begin
        got_inv = 1'b1;
        i_way   = WAY_W'(w);
      end
    end
    if (got_match)    fill_way = m_way;
    else if (got_inv) fill_way = i_way;
    else              fill_way = vic_way;
  end

  // Clock enables for storage and replacement state
  assign wr_en   = fill_en && !flush;
  assign upd_en  = wr_en || any_match;
  assign upd_set = wr_en ? fl_set   : lk_set;
  assign upd_way = wr_en ? fill_way : lk_way;
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
  import tlb_pkg::*;
#(
  parameter int unsigned FRM_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [LIN_W-1:0] lk_lin,
  input logic             lk_user,
  input logic             lk_hit,
  input logic             lk_pfault,
  input logic [LIN_W-1:0] lk_phys,
  input logic             walk_req,
  input logic             fill_en,
  input logic [LIN_W-1:0] fill_lin,
  input logic [FRM_W-1:0] fill_frame,
  input logic             flush
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_pfault, walk_req})); // R12

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_pfault || walk_req)); // R12

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_phys[PG_OFF_W-1:0] == lk_lin[PG_OFF_W-1:0]); // R3

  AST_MISS_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> lk_phys == '0); // R4

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush) && lk_valid) |-> walk_req); // R10 R11

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_en && !flush) && lk_valid && !lk_user &&
     lk_lin[LIN_W-1:PG_OFF_W] == $past(fill_lin[LIN_W-1:PG_OFF_W]))
    |-> (lk_hit && lk_phys[LIN_W-1:PG_OFF_W] == $past(fill_frame))); // R7 R9
endmodule

bind tlb_top tlb_chk #(.FRM_W(FRM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_lin(lk_lin),
  .lk_user(lk_user), .lk_hit(lk_hit), .lk_pfault(lk_pfault),
  .lk_phys(lk_phys), .walk_req(walk_req), .fill_en(fill_en),
  .fill_lin(fill_lin), .fill_frame(fill_frame), .flush(flush)
);

// File: tb/tlb_top_test.sv
module tlb_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        lk_valid, lk_user, lk_write;
  logic [31:0] lk_lin, lk_phys, fill_lin;
  logic        lk_hit, lk_pfault, walk_req;
  logic        fill_en, fill_usr, fill_wr, flush;
  logic [19:0] fill_frame;

  int total = 0;
  int bad   = 0;

  tlb_top uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_lin(lk_lin),
    .lk_user(lk_user), .lk_write(lk_write), .lk_hit(lk_hit),
    .lk_pfault(lk_pfault), .lk_phys(lk_phys), .walk_req(walk_req),
    .fill_en(fill_en), .fill_lin(fill_lin), .fill_frame(fill_frame),
    .fill_usr(fill_usr), .fill_wr(fill_wr), .flush(flush)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {lin, user, write, outcome(0 miss,1 hit,2 fault), frame}
  localparam logic [55:0] VEC [13] = '{
    {32'h0080_0ABC, 1'b1, 1'b1, 2'd1, 20'hA0000},  // R2 R3 user rw page
    {32'h0080_7123, 1'b1, 1'b0, 2'd1, 20'hA0070},  // R2 set 7
    {32'h0080_9FFF, 1'b1, 1'b0, 2'd1, 20'hA0011},  // R6 user read RO
    {32'h0080_9FFF, 1'b1, 1'b1, 2'd2, 20'h00000},  // R6 user write RO
    {32'h0080_9FFF, 1'b0, 1'b1, 2'd1, 20'hA0011},  // R6 sup write RO
    {32'h0081_2004, 1'b1, 1'b0, 2'd2, 20'h00000},  // R5 user read sup page
    {32'h0081_2004, 1'b0, 1'b0, 2'd1, 20'hA0022},  // R5 sup read
    {32'h0081_B010, 1'b0, 1'b1, 2'd1, 20'hA0033},  // R6 sup write sup RO
    {32'h0081_B010, 1'b1, 1'b1, 2'd2, 20'h00000},  // R5 user write sup RO
    {32'h0082_0000, 1'b0, 1'b0, 2'd0, 20'h00000},  // R4 absent tag
    {32'hFF80_5000, 1'b0, 1'b0, 2'd0, 20'h00000},  // R4 absent tag
    {32'h0081_E555, 1'b1, 1'b0, 2'd2, 20'h00000},  // R5 set 6
    {32'h0081_E555, 1'b0, 1'b0, 2'd1, 20'hA0063}   // R3 set 6
  };

  task automatic check(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] lin, input logic [19:0] frm,
                      input logic u, input logic w, input logic fl);
    @(negedge clk);
    fill_en = 1'b1; fill_lin = lin; fill_frame = frm;
    fill_usr = u; fill_wr = w; flush = fl;
    @(negedge clk);
    fill_en = 1'b0; flush = 1'b0;
  endtask

  task automatic look(input string rq, input logic [31:0] lin, input logic u,
                      input logic w, input int code, input logic [19:0] frm);
    logic [1:0]  act;
    logic [31:0] exp_phys;
    @(negedge clk);
    lk_valid = 1'b1; lk_lin = lin; lk_user = u; lk_write = w;
    #1;
    act = lk_hit ? 2'd1 : lk_pfault ? 2'd2 : walk_req ? 2'd0 : 2'd3;
    exp_phys = (code == 0) ? 32'h0 : {frm, lin[11:0]};
    check(act == 2'(code), rq, 64'(act), 64'(code));
    if (code != 2) check(lk_phys == exp_phys, rq, 64'(lk_phys), 64'(exp_phys));
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  function automatic logic [31:0] pg(input logic [16:0] tag, input logic [2:0] s);
    return {tag, s, 12'h000};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_lin = '0; lk_user = 1'b0; lk_write = 1'b0;
    fill_en = 1'b0; fill_lin = '0; fill_frame = '0; fill_usr = 1'b0;
    fill_wr = 1'b0; flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    look("R1", 32'h0080_0ABC, 1'b0, 1'b0, 0, 20'h0);
    look("R1", 32'h0000_0000, 1'b1, 1'b1, 0, 20'h0);

    // R12: idle lookup produces no outcome
    @(negedge clk); lk_lin = 32'h0080_0000; #1;
    check(!(lk_hit || lk_pfault || walk_req), "R12",
          64'({lk_hit, lk_pfault, walk_req}), 64'(0));

    // Populate all 32 entries: tag 0x100+w in set s, frame A0000|s<<4|w
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 4; w++)
        fill(pg(17'h100 + 17'(w), 3'(s)), 20'hA0000 | 20'(s << 4) | 20'(w),
             (w < 2), !w[0], 1'b0);

    // R2: every one of the 32 pages is resident
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 4; w++)
        look("R2", pg(17'h100 + 17'(w), 3'(s)) | 32'h123, 1'b0, 1'b0, 1,
             20'hA0000 | 20'(s << 4) | 20'(w));

    // Vector table
    for (int i = 0; i < 13; i++)
      look("R3 R4 R5 R6 table", VEC[i][55:24], VEC[i][23], VEC[i][22],
           int'(VEC[i][21:20]), VEC[i][19:0]);

    // R10: flush empties the array
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    look("R10", 32'h0080_0ABC, 1'b0, 1'b0, 0, 20'h0);
    look("R10", 32'h0081_E555, 1'b0, 1'b0, 0, 20'h0);

    // R11: fill coinciding with flush is lost
    fill(pg(17'h300, 3'd1), 20'h12345, 1'b1, 1'b1, 1'b1);
    look("R11", pg(17'h300, 3'd1), 1'b0, 1'b0, 0, 20'h0);

    // R7: four tags into set 5 all stay
    for (int i = 0; i < 4; i++)
      fill(pg(17'h200 + 17'(i), 3'd5), 20'h00100 + 20'(i), 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++)
      look("R7", pg(17'h200 + 17'(i), 3'd5), 1'b1, 1'b0, 1, 20'h00100 + 20'(i));

    // R8: tree now points at way 0 (A); E replaces A
    fill(pg(17'h204, 3'd5), 20'h00104, 1'b1, 1'b1, 1'b0);
    look("R8", pg(17'h200, 3'd5), 1'b0, 1'b0, 0, 20'h0);
    look("R8", pg(17'h201, 3'd5), 1'b0, 1'b0, 1, 20'h00101);
    // after touching B (way 1) the victim is way 2 (C)
    fill(pg(17'h205, 3'd5), 20'h00105, 1'b1, 1'b1, 1'b0);
    look("R8", pg(17'h202, 3'd5), 1'b0, 1'b0, 0, 20'h0);
    look("R8", pg(17'h203, 3'd5), 1'b0, 1'b0, 1, 20'h00103);
    look("R8", pg(17'h204, 3'd5), 1'b0, 1'b0, 1, 20'h00104);
    look("R8", pg(17'h205, 3'd5), 1'b0, 1'b0, 1, 20'h00105);

    // R9: refill of resident B replaces its frame in place
    fill(pg(17'h201, 3'd5), 20'hBEEF0, 1'b0, 1'b0, 1'b0);
    look("R9", pg(17'h201, 3'd5) | 32'hFFF, 1'b0, 1'b0, 1, 20'hBEEF0);
    look("R9", pg(17'h201, 3'd5), 1'b1, 1'b0, 2, 20'h0);
    look("R9", pg(17'h203, 3'd5), 1'b0, 1'b0, 1, 20'h00103);
    look("R9", pg(17'h204, 3'd5), 1'b0, 1'b0, 1, 20'h00104);
    look("R9", pg(17'h205, 3'd5), 1'b0, 1'b0, 1, 20'h00105);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule